// File: doc/BRIEF.md
# Auxiliary Register File with Address Unit

This block holds eight 16-bit address registers and a 3-bit pointer that selects one of them as the current register. In every cycle the current register drives the data-memory address output. In the same cycle an address arithmetic unit computes a post-modified copy of that register, and the copy is written back at the clock edge. A memory access and the index update for the next access therefore share one cycle, and the main datapath does no address arithmetic.

The modify command can step the current register by one in either direction, or by the contents of register 0, which acts as a programmable stride. Any register can be written through a load port, and the pointer has its own load. A second, independent read port returns any register, so software can spill or inspect values. The instruction decoder and the memory sit outside this block.

Top module: `ar_addr_unit`

## Requirements
- R1: While rst_ni is low, all eight registers and the pointer are zero. The block leaves reset with addr_o = 0 and rd_data_o = 0 for every rd_idx_i.
- R2: addr_o combinationally equals the register selected by the pointer, and shows its value before any modification made at the coming edge.
- R3: mod_i is decoded as 0 = no change, 1 = +1, 2 = -1, 3 = +register 0, 4 = -register 0. Codes 5 to 7 make no change. The result is written to the register the pointer selected before the edge.
- R4: Address arithmetic wraps modulo 2^16. For example, 0xFFFF + 1 gives 0x0000 and 0x0000 - 1 gives 0xFFFF.
- R5: With ld_en_i high, ld_val_i is written at the edge into the register numbered ld_idx_i. No other register changes because of the load.
- R6: If a load and a non-zero modify target the same register in one cycle, the loaded value is stored and the modify result is discarded.
- R7: A load of one register and a modify of a different register in the same cycle both take effect.
- R8: With ptr_ld_en_i high, the pointer takes ptr_val_i at the edge. A modify issued in that cycle still applies to the register selected by the old pointer.
- R9: A stride step uses the value register 0 held before the edge, even when register 0 is loaded or modified in that same cycle.
- R10: rd_data_o combinationally equals the register numbered rd_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Register load enable |
| ld_idx_i | input | 3 | Register number to load |
| ld_val_i | input | 16 | Value to load |
| ptr_ld_en_i | input | 1 | Pointer load enable |
| ptr_val_i | input | 3 | New pointer value |
| mod_i | input | 3 | Post-modify command for the current register |
| rd_idx_i | input | 3 | Read port register number |
| rd_data_o | output | 16 | Read port data |
| addr_o | output | 16 | Current register, used as the memory address |

## Verification
The hardest situations to reach are the ones where several write sources meet in a single cycle. Examples are a load and a modify hitting the same register, a pointer change together with a modify, and a stride step while register 0 is itself being rewritten or stepped. Directed sequences first set up each of these collisions with known register contents, including stride values that cross the 16-bit boundary. A long run with random inputs then puts loads, pointer changes and modify codes on narrow index ranges so that such overlaps happen often. A behavioural model in the bench is compared against both outputs on every cycle.

// File: rtl/ar_pkg.sv
package ar_pkg;
  localparam int unsigned AR_W   = 16;
  localparam int unsigned AR_N   = 8;
  localparam int unsigned IDX_W  = $clog2(AR_N);
  localparam int unsigned MOD_W  = 3;

  typedef logic [AR_W-1:0]  ar_word_t;
  typedef logic [IDX_W-1:0] ar_idx_t;

  typedef enum logic [MOD_W-1:0] {
    MOD_NONE = 3'd0,
    MOD_INC  = 3'd1,
    MOD_DEC  = 3'd2,
    MOD_ADDS = 3'd3,
    MOD_SUBS = 3'd4
  } mod_e;
endpackage

// File: rtl/ar_ptr_reg.sv
module ar_ptr_reg #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_val_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (ld_en_i) ptr_q <= ld_val_i;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ar_step_unit.sv
module ar_step_unit
  import ar_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]     base_i,
  input  logic [W-1:0]     stride_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic [W-1:0]     next_o,
  output logic             active_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] step;
  logic         sub;

  always_comb begin
    step     = '0;
    sub      = 1'b0;
    active_o = 1'b1;
    unique case (mod_i)
      MOD_INC:  step = ONE;
      MOD_DEC:  begin step = ONE; sub = 1'b1; end
      MOD_ADDS: step = stride_i;
      MOD_SUBS: begin step = stride_i; sub = 1'b1; end
      default:  active_o = 1'b0;
    endcase
  end

  // single adder: subtraction via two's complement, wraps mod 2^W
  assign next_o = base_i + (sub ? (~step + ONE) : step);
endmodule

// File: rtl/ar_regfile.sv
module ar_regfile #(
  parameter int unsigned W     = 16,
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [W-1:0]     ld_val_i,
  input  logic             mod_en_i,
  input  logic [IDX_W-1:0] mod_idx_i,
  input  logic [W-1:0]     mod_val_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [W-1:0]     cur_o,
  output logic [W-1:0]     rd_o,
  output logic [W-1:0]     reg0_o
);
  logic [N-1:0][W-1:0] regs_q;

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic ld_hit, mod_hit;
    assign ld_hit  = ld_en_i  && (ld_idx_i  == IDX_W'(g));
    assign mod_hit = mod_en_i && (mod_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      regs_q[g] <= '0;
      else if (ld_hit)  regs_q[g] <= ld_val_i;   // explicit load has priority
      else if (mod_hit) regs_q[g] <= mod_val_i;
    end
  end

  assign cur_o  = regs_q[cur_idx_i];
  assign rd_o   = regs_q[rd_idx_i];
  assign reg0_o = regs_q[0];
endmodule

// File: rtl/ar_addr_unit.sv
module ar_addr_unit
  import ar_pkg::*;
#(
  parameter int unsigned W     = AR_W,
  parameter int unsigned N     = AR_N,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [W-1:0]     ld_val_i,
  input  logic             ptr_ld_en_i,
  input  logic [IDX_W-1:0] ptr_val_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [W-1:0]     rd_data_o,
  output logic [W-1:0]     addr_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [W-1:0]     cur, reg0, mod_val;
  logic             mod_en;

  ar_ptr_reg #(.IDX_W(IDX_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_en_i  (ptr_ld_en_i),
    .ld_val_i (ptr_val_i),
    .ptr_o    (ptr_q)
  );

  ar_step_unit #(.W(W)) u_step (
    .base_i   (cur),
    .stride_i (reg0),
    .mod_i    (mod_i),
    .next_o   (mod_val),
    .active_o (mod_en)
  );

  ar_regfile #(.W(W), .N(N), .IDX_W(IDX_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_en_i   (ld_en_i),
    .ld_idx_i  (ld_idx_i),
    .ld_val_i  (ld_val_i),
    .mod_en_i  (mod_en),
    .mod_idx_i (ptr_q),
    .mod_val_i (mod_val),
    .cur_idx_i (ptr_q),
    .rd_idx_i  (rd_idx_i),
    .cur_o     (cur),
    .rd_o      (rd_data_o),
    .reg0_o    (reg0)
  );

  assign addr_o = cur;
endmodule

// File: rtl/ar_addr_unit_chk.sv
module ar_addr_unit_chk #(
  parameter int unsigned W     = 16,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ld_en_i,
  input logic [IDX_W-1:0] ld_idx_i,
  input logic [W-1:0]     ld_val_i,
  input logic             ptr_ld_en_i,
  input logic [IDX_W-1:0] ptr_val_i,
  input logic [2:0]       mod_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic [W-1:0]     rd_data_o,
  input logic [W-1:0]     addr_o,
  input logic [IDX_W-1:0] ptr_q
);
  logic ld_cur;
  assign ld_cur = ld_en_i && (ld_idx_i == ptr_q);

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (addr_o == '0 && rd_data_o == '0));

  assert_cur_matches_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == ptr_q) |-> (rd_data_o == addr_o));

  assert_inc_wraps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_i == 3'd1 && !ld_cur && !ptr_ld_en_i) |=> (addr_o == W'($past(addr_o) + 1'b1)));

  assert_dec_wraps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_i == 3'd2 && !ld_cur && !ptr_ld_en_i) |=> (addr_o == W'($past(addr_o) - 1'b1)));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mod_i == 3'd0 || mod_i > 3'd4) && !ld_cur && !ptr_ld_en_i) |=> $stable(addr_o));

  assert_load_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_cur && !ptr_ld_en_i) |=> (addr_o == $past(ld_val_i)));

  assert_ptr_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_ld_en_i |=> (ptr_q == $past(ptr_val_i)));
endmodule

bind ar_addr_unit ar_addr_unit_chk #(.W(W), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ld_en_i     (ld_en_i),
  .ld_idx_i    (ld_idx_i),
  .ld_val_i    (ld_val_i),
  .ptr_ld_en_i (ptr_ld_en_i),
  .ptr_val_i   (ptr_val_i),
  .mod_i       (mod_i),
  .rd_idx_i    (rd_idx_i),
  .rd_data_o   (rd_data_o),
  .addr_o      (addr_o),
  .ptr_q       (ptr_q)
);

// File: tb/ar_addr_unit_bench.sv
module ar_addr_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        ld_en_i = 1'b0;
  logic [2:0]  ld_idx_i = '0;
  logic [15:0] ld_val_i = '0;
  logic        ptr_ld_en_i = 1'b0;
  logic [2:0]  ptr_val_i = '0;
  logic [2:0]  mod_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic [15:0] rd_data_o, addr_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  int unsigned m_reg [8];
  int unsigned m_ptr;

  always #4 clk_i = ~clk_i;

  ar_addr_unit u_ar_addr_unit (.*);

  task automatic chk(string tag, string what, int unsigned act, int unsigned exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, compare outputs against model, advance model at edge
  task automatic cyc(string tag, bit le, int li, int lv, bit pe, int pv, int md, int ri);
    int unsigned nv, a0, p;
    @(negedge clk_i);
    ld_en_i = le; ld_idx_i = 3'(li); ld_val_i = 16'(lv);
    ptr_ld_en_i = pe; ptr_val_i = 3'(pv); mod_i = 3'(md); rd_idx_i = 3'(ri);
    #1;
    chk(tag, "addr_o", addr_o, m_reg[m_ptr]);
    chk(tag, "rd_data_o", rd_data_o, m_reg[ri & 7]);
    @(posedge clk_i);
    a0 = m_reg[0]; p = m_ptr; nv = m_reg[p];
    case (md & 7)
      1: nv = (nv + 1) & 16'hFFFF;
      2: nv = (nv + 16'hFFFF) & 16'hFFFF;
      3: nv = (nv + a0) & 16'hFFFF;
      4: nv = (nv + 32'h10000 - a0) & 16'hFFFF;
      default: ;
    endcase
    m_reg[p] = nv;
    if (le) m_reg[li & 7] = lv & 16'hFFFF;
    if (pe) m_ptr = pv & 7;
  endtask

  initial begin : watchdog
    #1_500_000;
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    foreach (m_reg[i]) m_reg[i] = 0;
    m_ptr = 0;
    #2 rst_ni = 1'b0;
    #1;
    chk("R1", "addr_o in reset", addr_o, 0);
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1: every register reads zero after reset
    for (int i = 0; i < 8; i++) cyc("R1", 0, 0, 0, 0, 0, 0, i);
    // R5/R10: load distinct values into all registers, read back
    for (int i = 0; i < 8; i++) cyc("R5", 1, i, 16'h1100 * (i + 1) + i, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc("R10", 0, 0, 0, 0, 0, 0, i);
    // R2/R8: walk the pointer
    for (int i = 0; i < 8; i++) cyc("R8", 0, 0, 0, 1, i, 0, i);
    cyc("R2", 0, 0, 0, 1, 3, 0, 3);
    // R3: every code on register 3, stride 0x0010
    cyc("R3", 1, 0, 16'h0010, 0, 0, 0, 0);
    for (int c = 0; c < 8; c++) begin
      cyc("R3", 0, 0, 0, 0, 0, c, 3);
      cyc("R3", 0, 0, 0, 0, 0, 0, 3);
    end
    // R4: wrap cases
    cyc("R4", 1, 3, 16'hFFFF, 0, 0, 0, 3);
    cyc("R4", 0, 0, 0, 0, 0, 1, 3);
    cyc("R4", 0, 0, 0, 0, 0, 2, 3);
    cyc("R4", 0, 0, 0, 0, 0, 0, 3);
    cyc("R4", 1, 0, 16'h8000, 0, 0, 0, 0);
    cyc("R4", 1, 3, 16'h9000, 0, 0, 3, 3);
    cyc("R4", 0, 0, 0, 0, 0, 3, 3);
    cyc("R4", 0, 0, 0, 0, 0, 4, 3);
    cyc("R4", 0, 0, 0, 0, 0, 4, 3);
    cyc("R4", 0, 0, 0, 0, 0, 0, 3);
    // R6: load and modify on the current register
    cyc("R6", 1, 3, 16'h1234, 0, 0, 1, 3);
    cyc("R6", 1, 3, 16'h0042, 0, 0, 4, 3);
    cyc("R6", 0, 0, 0, 0, 0, 0, 3);
    // R7: load another register while modifying current
    cyc("R7", 1, 5, 16'hABCD, 0, 0, 1, 5);
    cyc("R7", 0, 0, 0, 0, 0, 0, 5);
    cyc("R7", 0, 0, 0, 0, 0, 0, 3);
    // R8: pointer change with modify targets old register
    cyc("R8", 0, 0, 0, 1, 6, 2, 3);
    cyc("R8", 0, 0, 0, 0, 0, 0, 3);
    cyc("R8", 0, 0, 0, 0, 0, 0, 6);
    // R9: stride uses old register 0 while it is reloaded
    cyc("R9", 1, 0, 16'h0001, 1, 2, 0, 0);
    cyc("R9", 1, 0, 16'h0100, 0, 0, 3, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 2);
    cyc("R9", 0, 0, 0, 1, 0, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 3, 0);
    cyc("R9", 0, 0, 0, 0, 0, 4, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0, 0);
    // random mix on narrow ranges to force collisions
    for (int n = 0; n < 3000; n++) begin
      int li, pv, md;
      li = $urandom_range(0, 3);
      pv = $urandom_range(0, 3);
      md = $urandom_range(0, 7);
      cyc("R3", $urandom_range(0, 3) == 0, li,
          ($urandom_range(0, 7) == 0) ? 16'hFFFF : $urandom_range(0, 65535),
          $urandom_range(0, 5) == 0, pv, md, $urandom_range(0, 7));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule